// File: doc/BRIEF.md
# Hybrid Cellular Automaton Test Pattern Generator

This block is a one-dimensional row of single-bit cells that together produce a stream of pseudorandom vectors for on-chip self-test. On every enabled clock each cell takes a new value that depends only on three bits: its own value, the value of the cell above it (its left neighbour) and the value of the cell below it (its right neighbour). Which function of those three bits a cell applies is set by its own 8-bit rule number. Every cell may carry the same rule (a uniform array) or the cells may carry different rules (a hybrid array).

A single control input sets what the cells at the two ends see beyond the row. In null mode they see a constant zero. In cyclic mode the row closes into a ring. A seed can be loaded in parallel at any time. The full state is presented on a parallel output so that it can drive the inputs of the logic under test.

Top module: `hca_pattern_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the state becomes all zeros on that edge. Reset takes priority over every other input.
- R2: Cell i uses rule number `rules_i[8*i+7:8*i]`. On an enabled step its next value is bit k of that rule, where k = 4*left + 2*self + 1*right. For example, rule 102 gives self XOR right, rule 90 gives left XOR right, and rule 150 gives left XOR self XOR right.
- R3: Cell 0 is the least significant bit of `state_o`. The left neighbour of cell i is cell i+1 and its right neighbour is cell i-1.
- R4: With `cyclic_i` = 0, the left neighbour of the top cell and the right neighbour of cell 0 read as 0.
- R5: With `cyclic_i` = 1, the left neighbour of the top cell is cell 0 and the right neighbour of cell 0 is the top cell.
- R6: When `load_i` is high at a clock edge, the state takes `seed_i` on that edge, whatever `enable_i`, `rules_i` and `cyclic_i` hold.
- R7: When both `load_i` and `enable_i` are low, the state holds its value.
- R8: With 4 cells, rules 90,150,90,150 on cells 0..3, null boundary and seed 4'b0001, the state first returns to the seed after exactly 15 enabled steps.
- R9: Under rules whose bit 0 is 0 (such as 90 and 150), an all-zero state stays all-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Loads the seed into the state |
| seed_i | input | WIDTH | Parallel seed value |
| enable_i | input | 1 | Advances the automaton one step |
| rules_i | input | 8*WIDTH | Rule number of each cell, cell 0 in the low byte |
| cyclic_i | input | 1 | 1 selects ring boundary, 0 selects zero boundary |
| state_o | output | WIDTH | Current state of all cells |

## Verification
A wrong rule lookup, a swapped neighbour or a bad boundary connection shows up on `state_o` one clock after the first enabled step that hits the faulty neighbourhood. The bench therefore loads each of the 16 states of a 4-cell array and steps it once under several uniform and hybrid rule sets in both boundary modes. This reaches every neighbourhood of every cell, including both end cells. A fault that only disturbs the sequence over many steps, such as a wrong feedback that shortens the cycle, shows up as a period other than 15 in the maximal-length run.

// File: rtl/hca_pkg.sv
// Package: shared types and the rule evaluation helper for the
// cellular automaton pattern generator.
// Assumes: rules are 8-bit truth tables indexed by {left, self, right}.
package hca_pkg;

    localparam int RULE_BITS = 8;
    localparam int NBR_BITS  = 3;

    typedef logic [RULE_BITS-1:0] rule_t;
    typedef logic [NBR_BITS-1:0]  nbr_t;

    // Boundary handling selected by the cyclic control input.
    typedef enum logic {
        EDGE_NULL   = 1'b0,
        EDGE_CYCLIC = 1'b1
    } edge_mode_e;

    // Returns the truth-table entry of a rule for one neighbourhood.
    function automatic logic rule_eval(input rule_t rule, input nbr_t nbr);
        return rule[nbr];
    endfunction

endpackage

// File: rtl/hca_edge_sel.sv
// Module: hca_edge_sel
// Works out the left and right neighbour bit of every cell from the
// current state. Interior cells see their direct neighbours. The two end
// cells see either zero or the opposite end, depending on the edge mode.
// Assumes: WIDTH >= 2; cell 0 is the least significant bit.
module hca_edge_sel
    import hca_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] state_i,
    input  edge_mode_e       mode_i,
    output logic [WIDTH-1:0] left_o,
    output logic [WIDTH-1:0] right_o
);

    localparam int TOP = WIDTH - 1;

    logic top_left;
    logic bot_right;

    // Purpose: pick the out-of-range neighbours for the end cells.
    always_comb begin
        if (mode_i == EDGE_CYCLIC) begin
            top_left  = state_i[0];
            bot_right = state_i[TOP];
        end else begin
            top_left  = 1'b0;
            bot_right = 1'b0;
        end
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_nbr
        if (i == TOP) begin : g_top
            assign left_o[i] = top_left;
        end else begin : g_lin
            assign left_o[i] = state_i[i+1];
        end
        if (i == 0) begin : g_bot
            assign right_o[i] = bot_right;
        end else begin : g_rin
            assign right_o[i] = state_i[i-1];
        end
    end

endmodule

// File: rtl/hca_cell.sv
// Module: hca_cell
// One automaton cell: a single flip-flop whose next value is read from
// its own rule at the index formed by its three-bit neighbourhood.
// Priority: synchronous reset, then seed load, then enabled step; the
// cell holds its value otherwise.
// Assumes: nbr_i is {left, self, right} with self equal to q_o.
module hca_cell
    import hca_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load_i,
    input  logic  seed_i,
    input  logic  enable_i,
    input  rule_t rule_i,
    input  nbr_t  nbr_i,
    output logic  q_o
);

    logic next_bit;

    // Purpose: look the next value up in this cell's rule.
    always_comb begin
        next_bit = rule_eval(rule_i, nbr_i);
    end

    // Purpose: hold or update the cell flip-flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= 1'b0;
        end else if (load_i) begin
            q_o <= seed_i;
        end else if (enable_i) begin
            q_o <= next_bit;
        end
    end

    // R2: an enabled step stores the rule bit chosen by the previous neighbourhood.
    p_cell_rule_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && !load_i) |=> (q_o == $past(rule_i[nbr_i])));

endmodule

// File: rtl/hca_pattern_gen.sv
// Module: hca_pattern_gen
// Top level of the cellular automaton test pattern generator. A row of
// WIDTH cells, each with its own 8-bit rule, steps when enabled. The edge
// selector supplies the end-cell neighbours for null or cyclic mode.
// Assumes: WIDTH >= 2; rules_i holds cell 0's rule in its low byte.
module hca_pattern_gen
    import hca_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_i,
    input  logic [WIDTH-1:0]       seed_i,
    input  logic                   enable_i,
    input  logic [WIDTH*RULE_BITS-1:0] rules_i,
    input  logic                   cyclic_i,
    output logic [WIDTH-1:0]       state_o
);

    logic [WIDTH-1:0] state_w;
    logic [WIDTH-1:0] left_w;
    logic [WIDTH-1:0] right_w;
    edge_mode_e       mode_w;

    assign mode_w = cyclic_i ? EDGE_CYCLIC : EDGE_NULL;

    hca_edge_sel #(.WIDTH(WIDTH)) u_edge (
        .state_i (state_w),
        .mode_i  (mode_w),
        .left_o  (left_w),
        .right_o (right_w)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        hca_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_i   (load_i),
            .seed_i   (seed_i[i]),
            .enable_i (enable_i),
            .rule_i   (rules_i[i*RULE_BITS +: RULE_BITS]),
            .nbr_i    ({left_w[i], state_w[i], right_w[i]}),
            .q_o      (state_w[i])
        );
    end

    assign state_o = state_w;

    // Purpose: remember that reset was asserted on the previous edge.
    logic rst_seen_q;
    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
    end

    // R1: an edge with reset low leaves the state all zeros.
    always_ff @(posedge clk) begin
        if (rst_seen_q) begin
            p_reset_clear_r1: assert (state_o == '0);
        end
    end

    // R6: a load puts the seed on the output at the next edge.
    p_load_seed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (state_o == $past(seed_i)));

    // R7: no load and no enable keeps the state unchanged.
    p_hold_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !enable_i) |=> $stable(state_o));

endmodule

// File: tb/hca_pattern_gen_test.sv
// Bench: 4-cell array, every state stepped once under several rule sets
// and both boundary modes, plus load, hold, reset and period checks.
module hca_pattern_gen_test;

    localparam int W = 4;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           load_i;
    logic [W-1:0]   seed_i;
    logic           enable_i;
    logic [W*8-1:0] rules_i;
    logic           cyclic_i;
    logic [W-1:0]   state_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    hca_pattern_gen #(.WIDTH(W)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_i),
        .seed_i   (seed_i),
        .enable_i (enable_i),
        .rules_i  (rules_i),
        .cyclic_i (cyclic_i),
        .state_o  (state_o)
    );

    // Expected next state from R2..R5.
    function automatic logic [W-1:0] model(input logic [W-1:0] s,
                                           input logic [W*8-1:0] rs,
                                           input logic cyc);
        logic [W-1:0] n;
        for (int i = 0; i < W; i++) begin
            logic l, r;
            logic [7:0] ru;
            logic [2:0] k;
            l  = (i == W-1) ? (cyc ? s[0] : 1'b0) : s[i+1];
            r  = (i == 0) ? (cyc ? s[W-1] : 1'b0) : s[i-1];
            ru = rs[i*8 +: 8];
            k  = {l, s[i], r};
            n[i] = ru[k];
        end
        return n;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // One clock: inputs set at negedge, result sampled at next negedge.
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic load_seed(input logic [W-1:0] s);
        load_i = 1'b1; seed_i = s; tick(); load_i = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W*8-1:0] sets [4];
        sets[0] = 32'h66666666;                 // uniform 102
        sets[1] = {8'd150, 8'd90, 8'd150, 8'd90}; // hybrid 90/150
        sets[2] = {8'd30, 8'd102, 8'd60, 8'd105}; // mixed hybrid
        sets[3] = 32'h1E1E1E1E;                 // uniform 30

        rst_n = 1'b0; load_i = 1'b0; seed_i = '0; enable_i = 1'b1;
        rules_i = sets[1]; cyclic_i = 1'b0;
        @(negedge clk); tick();
        check("R1 reset", state_o, 4'b0000);

        // R1: reset beats load
        load_i = 1'b1; seed_i = 4'b1010; tick();
        check("R1 reset over load", state_o, 4'b0000);
        load_i = 1'b0; rst_n = 1'b1;

        // R6: load with enable high and ignores rules
        enable_i = 1'b1; load_seed(4'b1011);
        check("R6 load seed", state_o, 4'b1011);

        // R7: hold
        enable_i = 1'b0; tick(); tick();
        check("R7 hold", state_o, 4'b1011);

        // R6: load while enable low
        load_seed(4'b0110);
        check("R6 load without enable", state_o, 4'b0110);

        // R2..R5 sweep: every state, every rule set, both boundaries
        for (int c = 0; c < 2; c++) begin
            for (int r = 0; r < 4; r++) begin
                for (int s = 0; s < 16; s++) begin
                    rules_i = sets[r]; cyclic_i = c[0]; enable_i = 1'b0;
                    load_seed(s[W-1:0]);
                    enable_i = 1'b1; tick(); enable_i = 1'b0;
                    check(c ? "R2 R3 R5 cyclic step" : "R2 R3 R4 null step",
                          state_o, model(s[W-1:0], sets[r], c[0]));
                end
            end
        end

        // R9: zero stays zero under 90/150
        rules_i = sets[1]; cyclic_i = 1'b0;
        load_seed(4'b0000);
        enable_i = 1'b1; tick(); tick(); tick(); enable_i = 1'b0;
        check("R9 zero fixed", state_o, 4'b0000);

        // R8: period of the maximal 90/150 hybrid
        load_seed(4'b0001);
        enable_i = 1'b1;
        begin
            int steps = 0;
            bit zero_hit = 0;
            do begin
                tick(); steps++;
                if (state_o == 4'b0000) zero_hit = 1;
            end while (state_o != 4'b0001 && steps < 40);
            enable_i = 1'b0;
            check("R8 period", steps[W-1:0], 4'd15);
            checks++;
            if (steps != 15) begin
                errors++;
                $display("FAIL R8 period count: actual %0d expected 15", steps);
            end
            check("R8 no zero state", {3'b000, zero_hit}, 4'b0000);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule